// File: doc/BRIEF.md
# NAND Bus Control Latch

This block sits between a host register interface and a byte-wide NAND-type flash card. The host programs a control register that drives the flash card's address-latch, command-latch, chip-enable and power lines. It moves command, address and data bytes through a data-line register, and it reads a status register that reflects the card's busy, presence and write-protect inputs. A data-line access may be one byte or a 32-bit word. A word access is split into four single-cycle flash strobes, with the lowest byte going first.

The write-permit line to the card is not under direct software control. The latch turns it on when it sees an erase-setup or program-setup command byte pass through the command latch. It turns it off when software drops chip enable. A reset bit in the control register holds the engine in reset. Data-line writes made while that bit is set produce no strobe and have no effect.

Each access starts with a one-cycle request. The block raises a busy flag until the access completes, and it pulses a done flag for one cycle. During that done cycle, read data is valid.

Top module: `nand_bus_latch`

## Requirements
- R1: After a control write (register address 0), flashAle follows data bit 0 and flashCle follows bit 1. Bit 2 drives both flashCe and flashPower, so the two lines are always equal.
- R2: A control read (address 0) returns ALE in bit 0, CLE in bit 1, chip enable in bit 2, the write-permit state in bit 3 and the reset bit in bit 4. All higher bits read as zero.
- R3: A data-line write (address 1) of one byte gives exactly one flashWeStb cycle carrying bits 7:0. A word write gives four consecutive strobe cycles carrying bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R4: A data-line read of one byte gives one flashReStb cycle and returns the sampled byte in bits 7:0, with the upper bits zero. A word read gives four strobes, and the n-th sampled byte is placed in bits 8n+7:8n.
- R5: A byte of 0x60 strobed to the card turns write permit on, provided CLE and chip enable are both active.
- R6: A byte of 0x80 strobed to the card under the same conditions also turns write permit on. Neither command byte has any effect while CLE is low.
- R7: A control write with bit 2 clear turns write permit off. A control write with bit 2 set leaves write permit unchanged, whatever value is written to bit 3. Write permit is never on while chip enable is off.
- R8: A status read (address 2) returns the card busy input in bit 0, the card present input in bit 1, the read-only input in bit 2 and the inverse of busy in bit 3.
- R9: While control bit 4 (reset) is set, a data-line write produces no strobe and leaves write permit unchanged. Writing the bit back to zero restores normal writes.
- R10: hostDone is a single-cycle pulse. A register access completes one cycle after it is accepted. A data-line access completes one cycle after its last strobe: cycle 2 for a byte access and cycle 5 for a word access.
- R11: After reset, every flash output is low, no access is in progress, and the control register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-cycle access request, accepted when not busy |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostWord | input | 1 | 1 = 32-bit data-line access, 0 = byte |
| hostAddr | input | 2 | 0 control, 1 data line, 2 status |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data, valid while hostDone is high |
| hostBusy | output | 1 | Access in progress |
| hostDone | output | 1 | Access complete pulse |
| flashAle | output | 1 | Address latch enable |
| flashCle | output | 1 | Command latch enable |
| flashCe | output | 1 | Chip (card) enable |
| flashPower | output | 1 | Card power-on, paired with flashCe |
| flashWrPermit | output | 1 | Hardware-gated write permission |
| flashWeStb | output | 1 | Write strobe, one cycle per byte |
| flashReStb | output | 1 | Read strobe, one cycle per byte |
| flashDout | output | 8 | Byte driven to the card during a write strobe |
| flashDin | input | 8 | Byte from the card, sampled at the end of a read strobe |
| cardBusy | input | 1 | Card busy indication |
| cardPresent | input | 1 | Card inserted indication |
| cardReadOnly | input | 1 | Card write-protect indication |

## Verification
The hardest case to reach is a command byte that turns on write permit while it sits in an upper lane of a word write. The byte has to reach the card several strobes after the request, with CLE and chip enable already set by an earlier control write. The stimulus table gets there by chaining control writes and data writes, so that 0x80 travels in byte 2 of a word. The directed tests then place the same command bytes under the engine reset and with CLE low, and confirm that write permit does not change.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES = 4;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned BEAT_W = $clog2(LANES);
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int unsigned CTL_ALE = 0;
  localparam int unsigned CTL_CLE = 1;
  localparam int unsigned CTL_CE  = 2;
  localparam int unsigned CTL_RST = 4;

  localparam logic [BYTE_W-1:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_PROG_SETUP  = 8'h80;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} nbl_state_e;

  typedef struct packed {
    logic              ctrlWr;
    logic              ctrlRd;
    logic              statRd;
    logic              dataStart;
    logic              weStb;
    logic              reStb;
    logic [BEAT_W-1:0] beat;
  } nbl_strobe_t;
endpackage

// File: rtl/nbl_ctrl.sv
module nbl_ctrl
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              engRst,
  output nbl_strobe_t       stb,
  output logic              hostBusy,
  output logic              hostDone
);
  nbl_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lastBeat;
  logic              isWrite;
  logic              accept;
  logic              toData;

  assign accept = (state == ST_IDLE) && hostReq;
  // a data-line write under engine reset is completed without strobes (R9)
  assign toData = (hostAddr == ADDR_DATA) && !(hostWrite && engRst);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beat     <= '0;
      lastBeat <= '0;
      isWrite  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            isWrite  <= hostWrite;
            beat     <= '0;
            lastBeat <= hostWord ? BEAT_W'(LANES - 1) : '0;
            state    <= toData ? ST_XFER : ST_DONE;
          end
        end
        ST_XFER: begin
          if (beat == lastBeat) state <= ST_DONE;
          else beat <= beat + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.ctrlWr    = accept && hostWrite && (hostAddr == ADDR_CTRL);
    stb.ctrlRd    = accept && !hostWrite && (hostAddr == ADDR_CTRL);
    stb.statRd    = accept && !hostWrite && (hostAddr == ADDR_STAT);
    stb.dataStart = accept && (hostAddr == ADDR_DATA);
    stb.weStb     = (state == ST_XFER) && isWrite;
    stb.reStb     = (state == ST_XFER) && !isWrite;
    stb.beat      = beat;
  end

  assign hostBusy = (state != ST_IDLE);
  assign hostDone = (state == ST_DONE);
endmodule

// File: rtl/nbl_datapath.sv
module nbl_datapath
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  nbl_strobe_t       stb,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic [BYTE_W-1:0] flashDin,
  input  logic              cardBusy,
  input  logic              cardPresent,
  input  logic              cardReadOnly,
  output logic [WORD_W-1:0] hostRdata,
  output logic [BYTE_W-1:0] flashDout,
  output logic              flashAle,
  output logic              flashCle,
  output logic              flashCe,
  output logic              flashWrPermit,
  output logic              engRst
);
  logic              aleQ, cleQ, ceQ, wpQ, rstQ;
  logic [WORD_W-1:0] wBuf;
  logic [BYTE_W-1:0] laneQ [LANES];
  logic [BYTE_W-1:0] curByte;
  logic [WORD_W-1:0] ctrlImage;
  logic [WORD_W-1:0] statImage;
  logic [WORD_W-1:0] loadImage;
  logic              cmdHit;

  assign curByte = wBuf[stb.beat*BYTE_W +: BYTE_W];
  assign cmdHit  = stb.weStb && cleQ && ceQ &&
                   ((curByte == CMD_ERASE_SETUP) || (curByte == CMD_PROG_SETUP));

  assign ctrlImage = {{(WORD_W-5){1'b0}}, rstQ, wpQ, ceQ, cleQ, aleQ};
  assign statImage = {{(WORD_W-4){1'b0}}, ~cardBusy, cardReadOnly, cardPresent, cardBusy};
  assign loadImage = stb.ctrlRd ? ctrlImage : statImage;

  // control latch; write permit is owned by hardware only (R5, R6, R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleQ <= 1'b0;
      cleQ <= 1'b0;
      ceQ  <= 1'b0;
      rstQ <= 1'b0;
      wpQ  <= 1'b0;
    end else if (stb.ctrlWr) begin
      aleQ <= hostWdata[CTL_ALE];
      cleQ <= hostWdata[CTL_CLE];
      ceQ  <= hostWdata[CTL_CE];
      rstQ <= hostWdata[CTL_RST];
      wpQ  <= wpQ & hostWdata[CTL_CE];
    end else if (cmdHit) begin
      wpQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wBuf <= '0;
    else if (stb.dataStart) wBuf <= hostWdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) laneQ[g] <= '0;
      else if (stb.ctrlRd || stb.statRd) laneQ[g] <= loadImage[g*BYTE_W +: BYTE_W];
      else if (stb.dataStart) laneQ[g] <= '0;
      else if (stb.reStb && (stb.beat == BEAT_W'(g))) laneQ[g] <= flashDin;
    end
    assign hostRdata[g*BYTE_W +: BYTE_W] = laneQ[g];
  end

  assign flashDout     = stb.weStb ? curByte : '0;
  assign flashAle      = aleQ;
  assign flashCle      = cleQ;
  assign flashCe       = ceQ;
  assign flashWrPermit = wpQ;
  assign engRst        = rstQ;
endmodule

// File: rtl/nand_bus_latch.sv
module nand_bus_latch
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              hostBusy,
  output logic              hostDone,
  output logic              flashAle,
  output logic              flashCle,
  output logic              flashCe,
  output logic              flashPower,
  output logic              flashWrPermit,
  output logic              flashWeStb,
  output logic              flashReStb,
  output logic [BYTE_W-1:0] flashDout,
  input  logic [BYTE_W-1:0] flashDin,
  input  logic              cardBusy,
  input  logic              cardPresent,
  input  logic              cardReadOnly
);
  nbl_strobe_t stb;
  logic        engRst;

  nbl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostWord(hostWord), .hostAddr(hostAddr), .engRst(engRst),
    .stb(stb), .hostBusy(hostBusy), .hostDone(hostDone)
  );

  nbl_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata),
    .flashDin(flashDin), .cardBusy(cardBusy), .cardPresent(cardPresent),
    .cardReadOnly(cardReadOnly), .hostRdata(hostRdata), .flashDout(flashDout),
    .flashAle(flashAle), .flashCle(flashCle), .flashCe(flashCe),
    .flashWrPermit(flashWrPermit), .engRst(engRst)
  );

  assign flashPower = flashCe;
  assign flashWeStb = stb.weStb;
  assign flashReStb = stb.reStb;
endmodule

// File: rtl/nbl_checker.sv
module nbl_checker (
  input logic clk,
  input logic rstN,
  input logic hostBusy,
  input logic hostDone,
  input logic flashCe,
  input logic flashWrPermit,
  input logic flashWeStb,
  input logic flashReStb,
  input logic engRst
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flashWeStb && flashReStb)); // R3
  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (flashWeStb || flashReStb) |-> (hostBusy && !hostDone)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone); // R10
  AST_WP_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    flashWrPermit |-> flashCe); // R7
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    engRst |-> !flashWeStb); // R9
  AST_WP_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWrPermit) |-> $past(flashWeStb)); // R5
endmodule

bind nand_bus_latch nbl_checker chk_i (
  .clk(clk), .rstN(rstN), .hostBusy(hostBusy), .hostDone(hostDone),
  .flashCe(flashCe), .flashWrPermit(flashWrPermit), .flashWeStb(flashWeStb),
  .flashReStb(flashReStb), .engRst(engRst)
);

// File: tb/nand_bus_latch_tb_top.sv
`timescale 1ns/1ps
module nand_bus_latch_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0, hostWord = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostBusy, hostDone;
  logic        flashAle, flashCle, flashCe, flashPower, flashWrPermit;
  logic        flashWeStb, flashReStb;
  logic [7:0]  flashDout;
  logic [7:0]  flashDin = '0;
  logic        cardBusy = 1'b0, cardPresent = 1'b0, cardReadOnly = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nand_bus_latch dut_i (.*);

  typedef struct packed {
    logic        wr;
    logic        word;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] expVal;
    logic [2:0]  expStb;
    logic        expWp;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 2'd0, 32'h04,       32'h0,        3'd0, 1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h06,       32'h0,        3'd0, 1'b0},
    '{1'b1, 1'b0, 2'd1, 32'h90,       32'h90,       3'd1, 1'b0},
    '{1'b1, 1'b0, 2'd1, 32'h60,       32'h60,       3'd1, 1'b1},
    '{1'b1, 1'b0, 2'd0, 32'h04,       32'h0,        3'd0, 1'b1},
    '{1'b1, 1'b1, 2'd1, 32'h44332211, 32'h44332211, 3'd4, 1'b1},
    '{1'b0, 1'b1, 2'd1, 32'h10,       32'h13121110, 3'd4, 1'b1},
    '{1'b0, 1'b0, 2'd1, 32'hA5,       32'hA5,       3'd1, 1'b1},
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h0C,       3'd0, 1'b1},
    '{1'b1, 1'b0, 2'd0, 32'h00,       32'h0,        3'd0, 1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h06,       32'h0,        3'd0, 1'b0},
    '{1'b1, 1'b1, 2'd1, 32'h11802233, 32'h11802233, 3'd4, 1'b1},
    '{1'b1, 1'b0, 2'd0, 32'h00,       32'h0,        3'd0, 1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h0C,       32'h0,        3'd0, 1'b0},
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h04,       3'd0, 1'b0}
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 1:     return "R1";
      2, 5:     return "R3";
      3:        return "R5";
      4, 9, 12, 13: return "R7";
      6, 7:     return "R4";
      8, 14:    return "R2";
      11:       return "R6";
      default:  return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic word, input logic [1:0] addr,
                        input logic [31:0] data, output logic [31:0] rd,
                        output logic [31:0] wrBytes, output int nStb, output int nCyc);
    int nWe = 0;
    int nRe = 0;
    rd = '0; wrBytes = '0; nCyc = 0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostWord = word; hostAddr = addr; hostWdata = data;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (c == 1) hostReq = 1'b0;
      if (flashWeStb) begin
        wrBytes[nWe*8 +: 8] = flashDout;
        nWe++;
      end
      if (flashReStb) begin
        flashDin = data[7:0] + 8'(nRe);
        nRe++;
      end
      if (hostDone) begin
        rd = hostRdata;
        nCyc = c;
        break;
      end
    end
    nStb = nWe + nRe;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, wb;
    int nStb, nCyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check({flashAle, flashCle, flashCe, flashPower, flashWrPermit, flashWeStb,
           flashReStb} == 7'b0 && flashDout == 8'h0, "R11", "pins after reset",
          {24'b0, flashDout}, 32'h0);
    check(!hostBusy && !hostDone, "R11", "idle after reset", {30'b0, hostBusy, hostDone}, 0);
    access(1'b0, 1'b0, 2'd0, 32'h0, rd, wb, nStb, nCyc);
    check(rd == 32'h0, "R11", "control reads zero", rd, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, VECS[i].word, VECS[i].addr, VECS[i].data, rd, wb, nStb, nCyc);
      check(nStb == int'(VECS[i].expStb), vecTag(i), "strobe count", nStb, VECS[i].expStb);
      check(nCyc == int'(VECS[i].expStb) + 1, "R10", "done cycle", nCyc, VECS[i].expStb + 1);
      check(flashWrPermit == VECS[i].expWp, vecTag(i), "write permit",
            flashWrPermit, VECS[i].expWp);
      if (!VECS[i].wr)
        check(rd == VECS[i].expVal, vecTag(i), "read data", rd, VECS[i].expVal);
      else if (VECS[i].addr == 2'd1)
        check(wb == VECS[i].expVal, vecTag(i), "bytes on card", wb, VECS[i].expVal);
      @(negedge clk);
      check(!hostDone, "R10", "done is one pulse", hostDone, 0);
    end

    // R1 pins
    access(1'b1, 1'b0, 2'd0, 32'h07, rd, wb, nStb, nCyc);
    check({flashAle, flashCle, flashCe, flashPower} == 4'hF, "R1", "all lines on",
          {flashAle, flashCle, flashCe, flashPower}, 4'hF);
    access(1'b1, 1'b0, 2'd0, 32'h01, rd, wb, nStb, nCyc);
    check({flashAle, flashCle, flashCe, flashPower} == 4'h8, "R1", "ale only",
          {flashAle, flashCle, flashCe, flashPower}, 4'h8);

    // R8 status
    cardBusy = 1'b1; cardPresent = 1'b1; cardReadOnly = 1'b0;
    access(1'b0, 1'b0, 2'd2, 32'h0, rd, wb, nStb, nCyc);
    check(rd == 32'h3, "R8", "status busy+present", rd, 32'h3);
    cardBusy = 1'b0; cardReadOnly = 1'b1;
    access(1'b0, 1'b1, 2'd2, 32'h0, rd, wb, nStb, nCyc);
    check(rd == 32'hE, "R8", "status ready+ro+present", rd, 32'hE);

    // R6 negative: CLE low, CE on
    access(1'b1, 1'b0, 2'd0, 32'h04, rd, wb, nStb, nCyc);
    access(1'b1, 1'b1, 2'd1, 32'h60806080, rd, wb, nStb, nCyc);
    check(nStb == 4 && !flashWrPermit, "R6", "commands without CLE", flashWrPermit, 0);

    // R9 reset holds off writes
    access(1'b1, 1'b0, 2'd0, 32'h16, rd, wb, nStb, nCyc);
    access(1'b1, 1'b0, 2'd1, 32'h60, rd, wb, nStb, nCyc);
    check(nStb == 0, "R9", "no strobe in reset", nStb, 0);
    check(!flashWrPermit, "R9", "permit unchanged in reset", flashWrPermit, 0);
    check(nCyc == 1, "R9", "ignored write completes", nCyc, 1);
    access(1'b0, 1'b0, 2'd0, 32'h0, rd, wb, nStb, nCyc);
    check(rd == 32'h16, "R9", "reset bit readback", rd, 32'h16);
    access(1'b1, 1'b0, 2'd0, 32'h06, rd, wb, nStb, nCyc);
    access(1'b1, 1'b0, 2'd1, 32'h60, rd, wb, nStb, nCyc);
    check(nStb == 1 && wb == 32'h60, "R9", "write after release", wb, 32'h60);
    check(flashWrPermit, "R9", "permit after release", flashWrPermit, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule